// File: doc/BRIEF.md
# Multi-queue DMA command scheduler

This block decides which of four command rings a DMA engine reads next. There is a paging ring, a graphics ring and two run-list rings. For each ring it keeps a write pointer, delivered by doorbell writes, and a wrapped read pointer. It also keeps a global read count that never wraps. It walks a fixed six-step rotation and grants the first ring that has pending work. The grant is a one-cycle pulse that carries the ring index and the address to read. The scheduler then holds until the packet engine reports, with a done pulse, how many 32-bit words the packet used.

A ring packet can start an indirect buffer. The done pulse then carries the buffer's base and length. From that point, the ring's grants come from the buffer instead of the ring itself. When the buffer is fully consumed, it is dropped and service resumes at the ring's saved read pointer. Doorbells for the two run-list rings are steered by comparing the doorbell offset with the offset registered for each ring.

Top module: `dma_ring_sched`

## Requirements
- R1: After reset, no grant is active, `busy` is 0, `slot` is 0, every read, write and global pointer is 0, and no indirect buffer is active.
- R2: When every ring has work, grants follow the queue order page(0), gfx(1), rl0(2), page(0), gfx(1), rl1(3) for slots 0 to 5, and the sequence repeats.
- R3: A ring with no pending work is skipped. When no ring has work, no grant is issued, `busy` stays 0 and `slot` keeps its value.
- R4: A grant is a single-cycle pulse of `gnt_valid`. For a ring, `gnt_addr` equals the ring base plus its read pointer. After a grant, `busy` stays 1 until a done pulse arrives.
- R5: A done pulse for a ring packet adds `done_len` to that ring's read pointer modulo 2^LG, where LG is the ring's log2 size. It adds the same amount, without wrapping, to the ring's global read count.
- R6: A doorbell write pointer is stored modulo 2^LG of the target ring.
- R7: A doorbell aimed at the ring being served updates only its write pointer. No further grant appears before the done pulse, and the new work is served in later rotation slots.
- R8: `db_sel` 0 targets page and 1 targets gfx. With `db_sel` 2, a doorbell goes to rl0 when `db_offset` equals `rl0_offset`; otherwise it goes to rl1 when `db_offset` equals `rl1_offset`. A doorbell matching neither offset, or one with `db_sel` 3, changes no pointer.
- R9: A done pulse on a ring packet with `done_ib_load` set and a nonzero `ib_len` activates that ring's indirect buffer at `ib_base` with read offset 0. That ring's later grants have `gnt_ib`=1 and address `ib_base` plus the buffer read offset. A zero length activates nothing.
- R10: Once the buffer read offset reaches `ib_len`, the buffer is deactivated. The ring's next grant uses base plus the ring read pointer saved before the buffer started, and buffer packets leave the ring pointers unchanged.
- R11: While `busy`, `slot` holds the served slot. The done pulse moves it to the next slot modulo 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_sel | input | 2 | Doorbell target: 0 page, 1 gfx, 2 run-list, 3 none |
| db_offset | input | OFFW | Doorbell offset used to steer run-list doorbells |
| db_wptr | input | PTRW | New write pointer in words |
| rl0_offset | input | OFFW | Doorbell offset registered for rl0 |
| rl1_offset | input | OFFW | Doorbell offset registered for rl1 |
| ring_base | input | 4*ADDRW | Ring base addresses, queue q at bits q*ADDRW |
| done_valid | input | 1 | Packet-done pulse |
| done_len | input | LENW | Words consumed by the finished packet |
| done_ib_load | input | 1 | Finished ring packet starts an indirect buffer |
| ib_base | input | ADDRW | Indirect buffer base address |
| ib_len | input | PTRW | Indirect buffer length in words |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_qid | output | 2 | Granted queue index |
| gnt_ib | output | 1 | Grant is served from the indirect buffer |
| gnt_addr | output | ADDRW | Read address of the granted packet |
| busy | output | 1 | A granted packet is in flight |
| slot | output | 3 | Rotation slot, 0 to 5 |
| ib_active | output | 4 | Indirect buffer active, one bit per queue |
| q_rptr | output | 4*PTRW | Wrapped ring read pointers |
| q_wptr | output | 4*PTRW | Ring write pointers |
| q_gptr | output | 4*GW | Unwrapped global read counts |

## Verification
The assertions rely on three properties of the inputs. `done_valid` pulses only while `busy` is high. `done_len` never exceeds the words still pending in the ring or buffer being served. `done_ib_load` is raised only on a ring packet, never on a buffer packet. Without these, the pointer-equality tests that decide pending work could be stepped over. The bench meets them by keeping a model of every ring and buffer and capping each length at the model's remaining distance. It refuses doorbells that would fill a ring completely, and it requests a buffer only when the served queue's model shows no active buffer.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  localparam int NQ    = 4;
  localparam int NSLOT = 6;

  typedef enum logic [1:0] {
    Q_PAGE = 2'd0,
    Q_GFX  = 2'd1,
    Q_RL0  = 2'd2,
    Q_RL1  = 2'd3
  } qid_e;

  // Queue served by each slot of the rotation.
  function automatic logic [1:0] slot_queue(input logic [2:0] s);
    case (s)
      3'd0, 3'd3: slot_queue = Q_PAGE;
      3'd1, 3'd4: slot_queue = Q_GFX;
      3'd2:       slot_queue = Q_RL0;
      default:    slot_queue = Q_RL1;
    endcase
  endfunction

  function automatic logic [2:0] slot_next(input logic [2:0] s);
    slot_next = (s >= 3'(NSLOT - 1)) ? 3'd0 : s + 3'd1;
  endfunction

  // Reduce a value modulo 2**lg (power-of-two ring size).
  function automatic logic [31:0] ring_fold(input logic [31:0] v, input int lg);
    ring_fold = v & ((32'd1 << lg) - 32'd1);
  endfunction

endpackage

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr
  import dma_sched_pkg::*;
#(
  parameter int PTRW  = 16,
  parameter int LENW  = 8,
  parameter int ADDRW = 32,
  parameter int GW    = 32,
  parameter int LG    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db_we,
  input  logic [PTRW-1:0]  db_wptr,
  input  logic             ring_adv,
  input  logic             ib_adv,
  input  logic [LENW-1:0]  adv_len,
  input  logic             ib_load,
  input  logic [ADDRW-1:0] ib_base_i,
  input  logic [PTRW-1:0]  ib_len_i,
  input  logic [ADDRW-1:0] base_i,
  output logic             pending,
  output logic             ib_active,
  output logic [ADDRW-1:0] rd_addr,
  output logic [PTRW-1:0]  rptr_o,
  output logic [PTRW-1:0]  wptr_o,
  output logic [GW-1:0]    gptr_o
);

  logic [PTRW-1:0]  rptr_q, wptr_q, ib_rp_q, ib_wp_q;
  logic [GW-1:0]    gptr_q;
  logic             ib_on_q;
  logic [ADDRW-1:0] ib_bs_q;

  logic [PTRW-1:0]  ring_next, ib_next, db_masked;
  logic             ib_drained;

  always_comb begin
    ring_next  = PTRW'(ring_fold(32'(rptr_q) + 32'(adv_len), LG));
    db_masked  = PTRW'(ring_fold(32'(db_wptr), LG));
    ib_next    = ib_rp_q + PTRW'(adv_len);
    ib_drained = (ib_next == ib_wp_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      gptr_q  <= '0;
      ib_on_q <= 1'b0;
      ib_rp_q <= '0;
      ib_wp_q <= '0;
      ib_bs_q <= '0;
    end else begin
      if (db_we) wptr_q <= db_masked;
      if (ring_adv) begin
        rptr_q <= ring_next;
        gptr_q <= gptr_q + GW'(adv_len);
        if (ib_load && (ib_len_i != '0)) begin
          ib_on_q <= 1'b1;
          ib_rp_q <= '0;
          ib_wp_q <= ib_len_i;
          ib_bs_q <= ib_base_i;
        end
      end
      if (ib_adv) begin
        ib_rp_q <= ib_next;
        if (ib_drained) ib_on_q <= 1'b0;
      end
    end
  end

  assign pending   = ib_on_q ? (ib_rp_q != ib_wp_q) : (rptr_q != wptr_q);
  assign ib_active = ib_on_q;
  assign rd_addr   = ib_on_q ? (ib_bs_q + ADDRW'(ib_rp_q)) : (base_i + ADDRW'(rptr_q));
  assign rptr_o    = rptr_q;
  assign wptr_o    = wptr_q;
  assign gptr_o    = gptr_q;

endmodule

// File: rtl/dma_rot_picker.sv
module dma_rot_picker
  import dma_sched_pkg::*;
(
  input  logic [2:0]    slot_i,
  input  logic [NQ-1:0] pend_i,
  output logic          hit_o,
  output logic [2:0]    hit_slot_o
);

  logic [2:0] probe;

  always_comb begin
    hit_o      = 1'b0;
    hit_slot_o = slot_i;
    probe      = slot_i;
    for (int k = 0; k < NSLOT; k++) begin
      if (!hit_o && pend_i[slot_queue(probe)]) begin
        hit_o      = 1'b1;
        hit_slot_o = probe;
      end
      probe = slot_next(probe);
    end
  end

endmodule

// File: rtl/dma_ring_sched.sv
module dma_ring_sched
  import dma_sched_pkg::*;
#(
  parameter int PTRW    = 16,
  parameter int LENW    = 8,
  parameter int ADDRW   = 32,
  parameter int GW      = 32,
  parameter int OFFW    = 10,
  parameter int PAGE_LG = 6,
  parameter int GFX_LG  = 6,
  parameter int RL0_LG  = 5,
  parameter int RL1_LG  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  db_valid,
  input  logic [1:0]            db_sel,
  input  logic [OFFW-1:0]       db_offset,
  input  logic [PTRW-1:0]       db_wptr,
  input  logic [OFFW-1:0]       rl0_offset,
  input  logic [OFFW-1:0]       rl1_offset,
  input  logic [4*ADDRW-1:0]    ring_base,
  input  logic                  done_valid,
  input  logic [LENW-1:0]       done_len,
  input  logic                  done_ib_load,
  input  logic [ADDRW-1:0]      ib_base,
  input  logic [PTRW-1:0]       ib_len,
  output logic                  gnt_valid,
  output logic [1:0]            gnt_qid,
  output logic                  gnt_ib,
  output logic [ADDRW-1:0]      gnt_addr,
  output logic                  busy,
  output logic [2:0]            slot,
  output logic [3:0]            ib_active,
  output logic [4*PTRW-1:0]     q_rptr,
  output logic [4*PTRW-1:0]     q_wptr,
  output logic [4*GW-1:0]       q_gptr
);

  // Named internal events
  logic [NQ-1:0]    db_hit;
  logic [NQ-1:0]    pend;
  logic [NQ-1:0]    ring_adv;
  logic [NQ-1:0]    ib_adv;
  logic             done_fire;
  logic             pick_hit;
  logic [2:0]       pick_slot;
  logic [1:0]       pick_q;
  logic [ADDRW-1:0] q_addr [NQ];

  // Doorbell steering; rl0 wins when both offsets match.
  always_comb begin
    db_hit    = '0;
    db_hit[0] = db_valid && (db_sel == 2'd0);
    db_hit[1] = db_valid && (db_sel == 2'd1);
    db_hit[2] = db_valid && (db_sel == 2'd2) && (db_offset == rl0_offset);
    db_hit[3] = db_valid && (db_sel == 2'd2) && (db_offset == rl1_offset) &&
                (db_offset != rl0_offset);
  end

  assign done_fire = busy && done_valid;

  for (genvar g = 0; g < NQ; g++) begin : g_ring
    localparam int LG_Q = (g == 0) ? PAGE_LG :
                          (g == 1) ? GFX_LG  :
                          (g == 2) ? RL0_LG  : RL1_LG;

    assign ring_adv[g] = done_fire && (gnt_qid == 2'(g)) && !gnt_ib;
    assign ib_adv[g]   = done_fire && (gnt_qid == 2'(g)) &&  gnt_ib;

    dma_ring_ptr #(
      .PTRW(PTRW), .LENW(LENW), .ADDRW(ADDRW), .GW(GW), .LG(LG_Q)
    ) ring_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .db_we     (db_hit[g]),
      .db_wptr   (db_wptr),
      .ring_adv  (ring_adv[g]),
      .ib_adv    (ib_adv[g]),
      .adv_len   (done_len),
      .ib_load   (done_ib_load),
      .ib_base_i (ib_base),
      .ib_len_i  (ib_len),
      .base_i    (ring_base[g*ADDRW +: ADDRW]),
      .pending   (pend[g]),
      .ib_active (ib_active[g]),
      .rd_addr   (q_addr[g]),
      .rptr_o    (q_rptr[g*PTRW +: PTRW]),
      .wptr_o    (q_wptr[g*PTRW +: PTRW]),
      .gptr_o    (q_gptr[g*GW +: GW])
    );
  end

  dma_rot_picker picker_i (
    .slot_i     (slot),
    .pend_i     (pend),
    .hit_o      (pick_hit),
    .hit_slot_o (pick_slot)
  );

  assign pick_q = slot_queue(pick_slot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      slot      <= '0;
      gnt_valid <= 1'b0;
      gnt_qid   <= '0;
      gnt_ib    <= 1'b0;
      gnt_addr  <= '0;
    end else begin
      gnt_valid <= 1'b0;
      if (!busy) begin
        if (pick_hit) begin
          busy      <= 1'b1;
          slot      <= pick_slot;
          gnt_valid <= 1'b1;
          gnt_qid   <= pick_q;
          gnt_ib    <= ib_active[pick_q];
          gnt_addr  <= q_addr[pick_q];
        end
      end else if (done_valid) begin
        busy <= 1'b0;
        slot <= slot_next(slot);
      end
    end
  end

endmodule

// File: rtl/dma_ring_sched_chk.sv
module dma_ring_sched_chk
  import dma_sched_pkg::*;
#(
  parameter int PTRW    = 16,
  parameter int PAGE_LG = 6,
  parameter int GFX_LG  = 6,
  parameter int RL0_LG  = 5,
  parameter int RL1_LG  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gnt_valid,
  input logic [1:0]        gnt_qid,
  input logic              gnt_ib,
  input logic              busy,
  input logic [2:0]        slot,
  input logic              pick_hit,
  input logic              done_valid,
  input logic [3:0]        ib_active,
  input logic [4*PTRW-1:0] q_wptr
);

  a_r4_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !gnt_valid);

  a_r4_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> busy);

  a_r7_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_valid) |=> !gnt_valid);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pick_hit) |=> ($stable(slot) && !gnt_valid));

  a_r11_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done_valid) |=> (slot == slot_next($past(slot))));

  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot < 3'(NSLOT));

  a_r9_ib_flag: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_ib == ib_active[gnt_qid]));

  for (genvar g = 0; g < NQ; g++) begin : g_mask
    localparam int LG_Q = (g == 0) ? PAGE_LG :
                          (g == 1) ? GFX_LG  :
                          (g == 2) ? RL0_LG  : RL1_LG;
    a_r6_wptr_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(q_wptr[g*PTRW +: PTRW]) >> LG_Q) == 32'd0);
  end

endmodule

bind dma_ring_sched dma_ring_sched_chk #(
  .PTRW(PTRW), .PAGE_LG(PAGE_LG), .GFX_LG(GFX_LG), .RL0_LG(RL0_LG), .RL1_LG(RL1_LG)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .gnt_valid  (gnt_valid),
  .gnt_qid    (gnt_qid),
  .gnt_ib     (gnt_ib),
  .busy       (busy),
  .slot       (slot),
  .pick_hit   (pick_hit),
  .done_valid (done_valid),
  .ib_active  (ib_active),
  .q_wptr     (q_wptr)
);

// File: tb/dma_ring_sched_tb.sv
`timescale 1ns/1ps
module dma_ring_sched_tb_top;

  localparam int PTRW = 8, LENW = 4, ADDRW = 16, GW = 16, OFFW = 4;
  localparam int RL0_OFF = 5, RL1_OFF = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic db_valid = 0; logic [1:0] db_sel = 0; logic [OFFW-1:0] db_offset = 0;
  logic [PTRW-1:0] db_wptr = 0;
  logic done_valid = 0; logic [LENW-1:0] done_len = 0; logic done_ib_load = 0;
  logic [ADDRW-1:0] ib_base = 0; logic [PTRW-1:0] ib_len = 0;
  logic gnt_valid, gnt_ib, busy;
  logic [1:0] gnt_qid; logic [ADDRW-1:0] gnt_addr; logic [2:0] slot;
  logic [3:0] ib_active;
  logic [4*PTRW-1:0] q_rptr, q_wptr; logic [4*GW-1:0] q_gptr;

  always #4 clk = ~clk;

  dma_ring_sched #(
    .PTRW(PTRW), .LENW(LENW), .ADDRW(ADDRW), .GW(GW), .OFFW(OFFW),
    .PAGE_LG(3), .GFX_LG(3), .RL0_LG(2), .RL1_LG(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_sel(db_sel),
    .db_offset(db_offset), .db_wptr(db_wptr),
    .rl0_offset(OFFW'(RL0_OFF)), .rl1_offset(OFFW'(RL1_OFF)),
    .ring_base({16'h4000, 16'h3000, 16'h2000, 16'h1000}),
    .done_valid(done_valid), .done_len(done_len), .done_ib_load(done_ib_load),
    .ib_base(ib_base), .ib_len(ib_len),
    .gnt_valid(gnt_valid), .gnt_qid(gnt_qid), .gnt_ib(gnt_ib), .gnt_addr(gnt_addr),
    .busy(busy), .slot(slot), .ib_active(ib_active),
    .q_rptr(q_rptr), .q_wptr(q_wptr), .q_gptr(q_gptr)
  );

  // Bench model
  int n_tests = 0, n_fail = 0;
  int m_w[4], m_r[4], m_g[4], m_ibon[4], m_ibr[4], m_ibw[4], m_ibb[4];
  int m_slot = 0, cur_q = 0, cur_slot = 0;
  int lg[4] = '{3, 3, 2, 2};
  int base[4] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000};
  int order[6] = '{0, 1, 2, 0, 1, 3};

  // Grant monitor: latched at the falling edge, consumed at rising edges.
  bit seen = 0; int s_q, s_ib, s_addr;
  always @(negedge clk) if (gnt_valid) begin
    seen = 1; s_q = gnt_qid; s_ib = gnt_ib; s_addr = gnt_addr;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int msk(int q); return (1 << lg[q]) - 1; endfunction
  function automatic int rdist(int q); return (m_w[q] - m_r[q]) & msk(q); endfunction
  function automatic int mdist(int q);
    return m_ibon[q] != 0 ? m_ibw[q] - m_ibr[q] : rdist(q);
  endfunction
  function automatic int rp(int q); return int'(q_rptr[q*PTRW +: PTRW]); endfunction
  function automatic int wp(int q); return int'(q_wptr[q*PTRW +: PTRW]); endfunction
  function automatic int gp(int q); return int'(q_gptr[q*GW +: GW]); endfunction

  // Doorbell; model follows R8 steering and R6 masking.
  task automatic ring(input int sel, input int off, input int w);
    int q;
    q = (sel == 0) ? 0 : (sel == 1) ? 1 :
        (sel == 2 && off == RL0_OFF) ? 2 : (sel == 2 && off == RL1_OFF) ? 3 : -1;
    @(negedge clk);
    db_valid = 1; db_sel = 2'(sel); db_offset = OFFW'(off); db_wptr = PTRW'(w);
    @(negedge clk);
    db_valid = 0;
    if (q >= 0) m_w[q] = w & msk(q);
  endtask

  task automatic wait_grant(output bit got);
    int pq, ps, any; int s0;
    any = 0; pq = 0; ps = 0;
    for (int k = 0; k < 6; k++) begin
      int idx;
      idx = (m_slot + k) % 6;
      if (any == 0 && mdist(order[idx]) != 0) begin any = 1; pq = order[idx]; ps = idx; end
    end
    got = 0;
    if (any == 0) begin
      @(negedge clk); s0 = slot;
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk("R3", "idle grant seen", seen, 0);
      chk("R3", "idle slot held", slot, s0);
      chk("R3", "idle busy", busy, 0);
      return;
    end
    for (int i = 0; i < 30 && !seen; i++) @(posedge clk);
    if (!seen) begin
      n_tests++; n_fail++;
      $display("FAIL R4 grant timeout: actual none expected queue %0d", pq);
      return;
    end
    seen = 0;
    chk("R2", "granted queue", s_q, pq);
    chk("R9", "grant ib flag", s_ib, m_ibon[pq]);
    chk("R4", "grant address", s_addr,
        (m_ibon[pq] != 0 ? m_ibb[pq] + m_ibr[pq] : base[pq] + m_r[pq]) & 16'hFFFF);
    @(negedge clk);
    chk("R4", "busy after grant", busy, 1);
    chk("R11", "slot while busy", slot, ps);
    cur_q = pq; cur_slot = ps; got = 1;
  endtask

  task automatic finish(input int len, input int ibl, input int ibb, input int ibn);
    int q;
    q = cur_q;
    @(negedge clk);
    done_valid = 1; done_len = LENW'(len); done_ib_load = ibl[0];
    ib_base = ADDRW'(ibb); ib_len = PTRW'(ibn);
    @(negedge clk);
    done_valid = 0; done_ib_load = 0;
    if (m_ibon[q] != 0) begin
      m_ibr[q] += len;
      if (m_ibr[q] == m_ibw[q]) m_ibon[q] = 0;
    end else begin
      m_r[q] = (m_r[q] + len) & msk(q);
      m_g[q] += len;
      if (ibl != 0 && ibn != 0) begin
        m_ibon[q] = 1; m_ibr[q] = 0; m_ibw[q] = ibn; m_ibb[q] = ibb;
      end
    end
    m_slot = (cur_slot + 1) % 6;
    chk("R11", "slot after done", slot, m_slot);
    chk("R4", "busy after done", busy, 0);
    chk("R5", "read pointer", rp(q), m_r[q]);
    chk("R5", "global read count", gp(q), m_g[q]);
    chk("R9/R10", "ib active vector", int'(ib_active),
        (m_ibon[3] << 3) | (m_ibon[2] << 2) | (m_ibon[1] << 1) | m_ibon[0]);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    bit got; bit ib_done; int exp_seq[6];
    for (int q = 0; q < 4; q++) begin
      m_w[q] = 0; m_r[q] = 0; m_g[q] = 0; m_ibon[q] = 0; m_ibr[q] = 0; m_ibw[q] = 0; m_ibb[q] = 0;
    end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "gnt_valid", gnt_valid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "slot", slot, 0);
    chk("R1", "ib_active", int'(ib_active), 0);
    for (int q = 0; q < 4; q++) begin
      chk("R1", "rptr", rp(q), 0);
      chk("R1", "wptr", wp(q), 0);
      chk("R1", "gptr", gp(q), 0);
    end
    rst_n = 1;
    @(negedge clk);

    // R6 masking of a doorbell pointer
    ring(0, 0, 13);
    chk("R6", "page wptr masked", wp(0), 5);
    wait_grant(got);
    // R8 steering while page is in flight
    ring(1, 0, 6);
    ring(2, RL0_OFF, 3);
    ring(2, RL1_OFF, 7);
    chk("R8", "rl0 wptr", wp(2), 3);
    chk("R8", "rl1 wptr masked", wp(3), 3);
    ring(2, 3, 1);
    ring(3, RL0_OFF, 2);
    chk("R8", "rl0 unchanged by stray", wp(2), 3);
    chk("R8", "rl1 unchanged by stray", wp(3), 3);
    chk("R8", "gfx unchanged by stray", wp(1), 6);
    // R7 doorbell to the in-flight ring
    ring(0, 0, 4);
    chk("R7", "in-flight wptr update", wp(0), 4);
    chk("R7", "in-flight rptr untouched", rp(0), 0);
    chk("R7", "no second grant", seen, 0);
    finish(1, 0, 0, 0);

    // R2 rotation with all rings busy
    exp_seq = '{1, 2, 0, 1, 3, 0};
    for (int i = 0; i < 6; i++) begin
      wait_grant(got);
      chk("R2", "rotation order", cur_q, exp_seq[i]);
      finish(1, 0, 0, 0);
    end

    // R9 R10 indirect buffer on gfx, then drain everything
    ib_done = 0;
    for (int i = 0; i < 200; i++) begin
      wait_grant(got);
      if (!got) break;
      if (!ib_done && cur_q == 1 && m_ibon[1] == 0) begin
        finish(1, 1, 16'h0800, 2);
        ib_done = 1;
        chk("R9", "gfx ib active", int'(ib_active[1]), 1);
      end else begin
        finish((mdist(cur_q) < 2) ? mdist(cur_q) : 2, 0, 0, 0);
      end
    end
    chk("R10", "gfx ib dropped", int'(ib_active[1]), 0);

    // Sweep: doorbells while busy, varied lengths, buffer loads incl. zero length
    for (int it = 0; it < 120; it++) begin
      int q, add;
      wait_grant(got);
      q = (it * 3) % 4;
      add = (it % 3) + 1;
      if (rdist(q) + add <= msk(q))
        ring(q < 2 ? q : 2, q == 2 ? RL0_OFF : RL1_OFF,
             m_w[q] + add + (msk(q) + 1) * (it % 2));
      if (it % 11 == 4) ring(2, 0, it);
      if (got) begin
        int want, len;
        want = (it % 3) + 1;
        len = (mdist(cur_q) < want) ? mdist(cur_q) : want;
        if (m_ibon[cur_q] == 0 && it % 5 == 2)
          finish(len, 1, 16'h0800 + it * 16, it % 3);
        else
          finish(len, 0, 0, 0);
      end
    end
    report();
  end

endmodule